// File: doc/BRIEF.md
# Multi-Channel Toggle and Dither Code Generator

This block turns per-channel input codes into the registered 16-bit codes that feed a bank of DAC channels. Each channel runs in one of three ways. In direct mode its output is loaded from input register A on a per-channel or a global update strobe. In toggle mode the output follows a selected square-wave source, showing A while the source is low and B while it is high. In dither mode the output traces a triangle centred on A, with B holding the amplitude. The dither advances one step per rising edge of the selected source.

A source is either the channel's own software toggle bit or one of three external toggle inputs. The external inputs are asynchronous and pass through a two-flop synchronizer before use. A per-channel power-down bit forces the output to zero and clears the dither position. All interfaces are plain level and strobe pins: codes and settings are held by the register file in front of the block, and the outputs are registered levels, so there is no handshake and no back-pressure.

Top module: `dac_wave_ctrl`

## Requirements
- R1: After reset every channel output code is 0x0000.
- R2: With its waveform enable clear and power-down clear, a channel loads A into its output one cycle after its own update strobe. Otherwise it holds its output, even when A changes, and the other channels are unaffected.
- R3: The global update strobe loads A into the output of every channel that is in direct mode, one cycle later.
- R4: With waveform enable set and mode bit 0 (toggle), the output is A while the selected source is low and B while it is high. Source select 0 is the channel's software toggle bit, and select 1, 2 and 3 are external inputs 0, 1 and 2.
- R5: In dither mode the amplitude is B[15:2], and B[1:0] has no effect on the output.
- R6: Period index 0 to 4 gives a dither period of 4, 8, 16, 32 or 64 source rising edges. Index 5 to 7 gives 64.
- R7: The 2-bit phase field advances the waveform position by phase x P/4 steps, where P is the period.
- R8: With position k = (n + phase·P/4) mod P after n source rising edges and Q = P/4, the offset is t = k for k<Q, t = 2Q−k for Q≤k<3Q, and t = k−4Q otherwise. The output is A + sign(t)·floor(amp·|t|/Q), clamped to the range 0x0000 to 0xFFFF.
- R9: An external input reaches the output three clock edges after it changes: two synchronizer flops and then the output register. Each rising edge of the selected source advances the dither position exactly once.
- R10: Power-down forces the output to 0x0000 one cycle later and clears the dither position. It overrides every strobe and mode.
- R11: In toggle or dither mode, the update strobes have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_a | input | NCH*CW | Input register A per channel, channel c at [c*CW +: CW] |
| code_b | input | NCH*CW | Input register B per channel (toggle code or amplitude in bits 15:2) |
| wave_en | input | NCH | Waveform enable per channel |
| dither_sel | input | NCH | Mode bit: 0 toggle, 1 dither |
| src_sel | input | NCH*2 | Source select per channel |
| per_idx | input | NCH*3 | Dither period index per channel |
| phase | input | NCH*2 | Dither quarter-period phase per channel |
| sw_tog | input | NCH | Software toggle bit per channel |
| pwr_dn | input | NCH | Power-down per channel |
| upd_ch | input | NCH | Per-channel update strobe |
| upd_all | input | 1 | Global update strobe |
| ext_tog | input | NEXT | Asynchronous external toggle inputs |
| dac_code | output | NCH*CW | Registered output code per channel |

## Verification
The assertions assume that a channel's period index, phase and mode stay fixed while its dither runs. They also assume that each source level is held long enough for the synchronizer to see every edge. The stimulus changes configuration only while every channel is powered down, and it holds each source level for four clock cycles. Random trials drive every source with the same number of rising edges, so each channel sees a known edge count whichever source it selects. Directed cases cover the synchronizer latency, saturation at both rails, and strobes issued during power-down.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  localparam int PIDX_W   = 3;
  localparam int PIDX_MAX = 4;
  localparam int CNT_W    = PIDX_MAX + 2;

  typedef enum logic [1:0] {
    CH_DIRECT = 2'd0,
    CH_TOGGLE = 2'd1,
    CH_DITHER = 2'd2,
    CH_OFF    = 2'd3
  } ch_mode_e;

  function automatic logic [PIDX_W-1:0] per_shift(input logic [PIDX_W-1:0] idx);
    return (idx > PIDX_W'(PIDX_MAX)) ? PIDX_W'(PIDX_MAX) : idx;
  endfunction
endpackage

// File: rtl/dwc_src_sync.sv
module dwc_src_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl  = lvl_q;
  assign rise = lvl_q & ~prev_q;

  p_rise_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/dwc_dither_core.sv
module dwc_dither_core
  import dwc_pkg::*;
#(
  parameter int AMP_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [PIDX_W-1:0] per_idx,
  input  logic [1:0]        phase,
  input  logic [AMP_W-1:0]  amp,
  output logic [AMP_W-1:0]  dev_mag,
  output logic              dev_neg
);
  localparam int AW = CNT_W + 1;
  localparam int PW = AMP_W + AW;

  logic [CNT_W-1:0]  cnt_q;
  logic [PIDX_W-1:0] sh;
  logic [AW-1:0]     qtr, pmask, pos, mag;
  logic [PW-1:0]     prod;

  always_comb begin
    sh    = per_shift(per_idx);
    qtr   = AW'(1) << sh;
    pmask = (AW'(4) << sh) - AW'(1);
    pos   = (AW'(cnt_q) + (AW'(phase) << sh)) & pmask;
    if (pos < qtr) begin
      mag     = pos;
      dev_neg = 1'b0;
    end else if (pos < (qtr << 1)) begin
      mag     = (qtr << 1) - pos;
      dev_neg = 1'b0;
    end else if (pos < ((qtr << 1) + qtr)) begin
      mag     = pos - (qtr << 1);
      dev_neg = 1'b1;
    end else begin
      mag     = (qtr << 2) - pos;
      dev_neg = 1'b1;
    end
    prod    = (PW'(amp) * PW'(mag)) >> sh;
    dev_mag = prod[AMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (step)     cnt_q <= (cnt_q + CNT_W'(1)) & pmask[CNT_W-1:0];
  end

  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(cnt_q));
  p_cnt_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  p_dev_le_amp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_mag <= amp);
endmodule

// File: rtl/dwc_channel.sv
module dwc_channel
  import dwc_pkg::*;
#(
  parameter int CW    = 16,
  parameter int NSRC  = 4,
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     a,
  input  logic [CW-1:0]     b,
  input  logic              en,
  input  logic              dith,
  input  logic [SEL_W-1:0]  sel,
  input  logic [PIDX_W-1:0] per_idx,
  input  logic [1:0]        phase,
  input  logic              pd,
  input  logic              upd,
  input  logic [NSRC-1:0]   src_lvl,
  input  logic [NSRC-1:0]   src_rise,
  output logic [CW-1:0]     code
);
  localparam int AMP_W = CW - 2;

  ch_mode_e         mode;
  logic             lvl, rise, dev_neg;
  logic [AMP_W-1:0] dev_mag;
  logic [CW:0]      up_sum;
  logic [CW-1:0]    dith_code, code_q, code_d;

  always_comb begin
    if (pd)        mode = CH_OFF;
    else if (!en)  mode = CH_DIRECT;
    else if (dith) mode = CH_DITHER;
    else           mode = CH_TOGGLE;
    lvl  = (int'(sel) < NSRC) ? src_lvl[sel]  : 1'b0;
    rise = (int'(sel) < NSRC) ? src_rise[sel] : 1'b0;
  end

  dwc_dither_core #(.AMP_W(AMP_W)) core_i (
    .clk(clk), .rst_n(rst_n), .clr(pd), .step(rise),
    .per_idx(per_idx), .phase(phase), .amp(b[CW-1:2]),
    .dev_mag(dev_mag), .dev_neg(dev_neg)
  );

  always_comb begin
    up_sum = {1'b0, a} + (CW+1)'(dev_mag);
    if (dev_neg)
      dith_code = (CW'(dev_mag) > a) ? '0 : a - CW'(dev_mag);
    else
      dith_code = up_sum[CW] ? '1 : up_sum[CW-1:0];
    unique case (mode)
      CH_OFF:    code_d = '0;
      CH_TOGGLE: code_d = lvl ? b : a;
      CH_DITHER: code_d = dith_code;
      default:   code_d = upd ? a : code_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code = code_q;

  p_off_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (code == '0));
  p_toggle_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_TOGGLE) |=> (code == $past(a) || code == $past(b)));
  p_direct_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_DIRECT && !upd) |=> $stable(code));
  p_dither_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_DITHER && !dev_neg) |=> (code >= $past(a)));
  p_dither_dn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_DITHER && dev_neg) |=> (code <= $past(a)));
endmodule

// File: rtl/dac_wave_ctrl.sv
module dac_wave_ctrl
  import dwc_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int CW   = 16,
  parameter int NEXT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*CW-1:0]     code_a,
  input  logic [NCH*CW-1:0]     code_b,
  input  logic [NCH-1:0]        wave_en,
  input  logic [NCH-1:0]        dither_sel,
  input  logic [NCH*2-1:0]      src_sel,
  input  logic [NCH*PIDX_W-1:0] per_idx,
  input  logic [NCH*2-1:0]      phase,
  input  logic [NCH-1:0]        sw_tog,
  input  logic [NCH-1:0]        pwr_dn,
  input  logic [NCH-1:0]        upd_ch,
  input  logic                  upd_all,
  input  logic [NEXT-1:0]       ext_tog,
  output logic [NCH*CW-1:0]     dac_code
);
  localparam int NSRC  = NEXT + 1;
  localparam int SEL_W = 2;

  logic [NEXT-1:0] ext_lvl, ext_rise;
  logic [NCH-1:0]  sw_prev_q, sw_rise;

  dwc_src_sync #(.N(NEXT)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(ext_tog),
    .lvl(ext_lvl), .rise(ext_rise)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sw_prev_q <= '0;
    else        sw_prev_q <= sw_tog;
  end
  assign sw_rise = sw_tog & ~sw_prev_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dwc_channel #(.CW(CW), .NSRC(NSRC), .SEL_W(SEL_W)) ch_i (
      .clk(clk), .rst_n(rst_n),
      .a(code_a[c*CW +: CW]), .b(code_b[c*CW +: CW]),
      .en(wave_en[c]), .dith(dither_sel[c]),
      .sel(src_sel[c*SEL_W +: SEL_W]),
      .per_idx(per_idx[c*PIDX_W +: PIDX_W]),
      .phase(phase[c*2 +: 2]),
      .pd(pwr_dn[c]), .upd(upd_ch[c] | upd_all),
      .src_lvl({ext_lvl, sw_tog[c]}),
      .src_rise({ext_rise, sw_rise[c]}),
      .code(dac_code[c*CW +: CW])
    );
  end
endmodule

// File: tb/dac_wave_ctrl_tb_top.sv
module dac_wave_ctrl_tb_top;
  localparam int NCH = 16;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NCH*CW-1:0] code_a, code_b, dac_code;
  logic [NCH-1:0]    wave_en, dither_sel, sw_tog, pwr_dn, upd_ch;
  logic [NCH*2-1:0]  src_sel, phase;
  logic [NCH*3-1:0]  per_idx;
  logic              upd_all;
  logic [2:0]        ext_tog;

  int total = 0;
  int bad   = 0;
  bit wd_hit = 1'b0;

  dac_wave_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .code_a(code_a), .code_b(code_b),
    .wave_en(wave_en), .dither_sel(dither_sel), .src_sel(src_sel),
    .per_idx(per_idx), .phase(phase), .sw_tog(sw_tog), .pwr_dn(pwr_dn),
    .upd_ch(upd_ch), .upd_all(upd_all), .ext_tog(ext_tog),
    .dac_code(dac_code)
  );

  function automatic logic [15:0] f_dither(input logic [15:0] a, input logic [15:0] b,
                                           input int idx, input int ph, input int n);
    int p, q, k, t, mag, dev, r;
    p = 4 << ((idx > 4) ? 4 : idx);
    q = p / 4;
    k = (n + ph * q) % p;
    if (k < q) t = k;
    else if (k < 3 * q) t = 2 * q - k;
    else t = k - 4 * q;
    mag = (t < 0) ? -t : t;
    dev = (int'(b >> 2) * mag) / q;
    r = (t < 0) ? int'(a) - dev : int'(a) + dev;
    if (r < 0) r = 0;
    if (r > 65535) r = 65535;
    return 16'(r);
  endfunction

  function automatic logic [15:0] out_of(input int c);
    return dac_code[c*CW +: CW];
  endfunction

  task automatic check(input string req, input int c, input logic [15:0] act,
                       input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s ch%0d actual=%h expected=%h", req, c, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic all_sources(input logic v);
    sw_tog  = {NCH{v}};
    ext_tog = {3{v}};
  endtask

  task automatic set_a(input int c, input logic [15:0] v);
    code_a[c*CW +: CW] = v;
  endtask

  task automatic set_b(input int c, input logic [15:0] v);
    code_b[c*CW +: CW] = v;
  endtask

  initial begin
    #1500000;
    wd_hit = 1'b1;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] hold_v [NCH];
    void'($urandom(32'd2024));
    code_a = '0; code_b = '0; wave_en = '0; dither_sel = '0; src_sel = '0;
    per_idx = '0; phase = '0; sw_tog = '0; pwr_dn = '0; upd_ch = '0;
    upd_all = 1'b0; ext_tog = '0;
    tick(3);
    for (int c = 0; c < NCH; c++) check("R1 reset", c, out_of(c), 16'h0000);
    rst_n = 1'b1;
    tick(2);

    // R2: single-channel strobe
    for (int c = 0; c < NCH; c++) set_a(c, 16'(16'h1000 + c * 16'h0111));
    upd_ch = 16'h0020;
    tick(1);
    upd_ch = '0;
    for (int c = 0; c < NCH; c++)
      check("R2 strobe", c, out_of(c), (c == 5) ? 16'h1555 : 16'h0000);
    set_a(5, 16'hBEEF);
    tick(3);
    check("R2 hold", 5, out_of(5), 16'h1555);

    // R3: global update
    upd_all = 1'b1;
    tick(1);
    upd_all = 1'b0;
    for (int c = 0; c < NCH; c++) check("R3 update all", c, out_of(c), code_a[c*CW +: CW]);

    // R10: power-down beats strobe
    pwr_dn = 16'h0003;
    upd_all = 1'b1;
    tick(1);
    upd_all = 1'b0;
    check("R10 pd over strobe", 0, out_of(0), 16'h0000);
    check("R10 pd over strobe", 1, out_of(1), 16'h0000);
    pwr_dn = '0;
    tick(1);

    // R9 and R4: external source latency on channel 2 (sel 2 = ext input 1)
    set_a(2, 16'h1111); set_b(2, 16'h2222);
    wave_en[2] = 1'b1; src_sel[5:4] = 2'd2;
    tick(4);
    check("R4 toggle low", 2, out_of(2), 16'h1111);
    ext_tog[1] = 1'b1;
    tick(2);
    check("R9 latency two edges", 2, out_of(2), 16'h1111);
    tick(1);
    check("R9 latency three edges", 2, out_of(2), 16'h2222);
    ext_tog[1] = 1'b0;
    wave_en = '0; src_sel = '0;
    tick(4);

    // R8 saturation at both rails: period 4, phase 0
    pwr_dn = '1;
    tick(2);
    set_a(0, 16'hFFF0); set_b(0, 16'hFFFF);
    set_a(1, 16'h0010); set_b(1, 16'hFFFF);
    wave_en[1:0] = 2'b11; dither_sel[1:0] = 2'b11;
    per_idx[5:0] = '0; phase[1:0] = 2'd0; phase[3:2] = 2'd1;
    pwr_dn = '0;
    tick(2);
    all_sources(1'b1); tick(4); all_sources(1'b0); tick(4);
    check("R8 saturate high", 0, out_of(0), 16'hFFFF);
    all_sources(1'b1); tick(4); all_sources(1'b0); tick(4);
    check("R8 saturate low", 1, out_of(1), 16'h0000);
    wave_en = '0; dither_sel = '0; phase = '0;

    // Random trials covering R4..R11
    for (int tr = 0; tr < 40; tr++) begin
      int n;
      bit fin_hi;
      pwr_dn = '1;
      all_sources(1'b0);
      tick(4);
      for (int c = 0; c < NCH; c++) begin
        set_a(c, 16'($urandom));
        set_b(c, 16'($urandom));
        wave_en[c]          = ($urandom % 3) != 0;
        dither_sel[c]       = $urandom % 2;
        src_sel[c*2 +: 2]   = 2'($urandom);
        per_idx[c*3 +: 3]   = 3'($urandom);
        phase[c*2 +: 2]     = 2'($urandom);
      end
      if (tr == 0) begin
        set_b(3, 16'h4003); wave_en[3] = 1'b1; dither_sel[3] = 1'b1;
        set_b(4, 16'h4000); wave_en[4] = 1'b1; dither_sel[4] = 1'b1;
        set_a(4, code_a[3*CW +: CW]);
        per_idx[14:9] = {3'd1, 3'd1}; phase[9:6] = '0;
      end
      n = 1 + ($urandom % 90);
      fin_hi = $urandom % 2;
      pwr_dn = '0;
      tick(2);
      for (int c = 0; c < NCH; c++)
        if (!wave_en[c]) check("R2 hold after pd", c, out_of(c), 16'h0000);
      for (int e = 0; e < n; e++) begin
        all_sources(1'b1);
        tick(4);
        if (e == n / 2) begin
          upd_ch = '1; upd_all = 1'b1; tick(1); upd_ch = '0; upd_all = 1'b0;
        end
        if (e != n - 1 || !fin_hi) begin
          all_sources(1'b0);
          tick(4);
        end
      end
      tick(4);
      for (int c = 0; c < NCH; c++) begin
        logic [15:0] a, b;
        a = code_a[c*CW +: CW];
        b = code_b[c*CW +: CW];
        if (!wave_en[c]) check("R3 direct after strobe", c, out_of(c), a);
        else if (!dither_sel[c]) check("R4 R11 toggle", c, out_of(c), fin_hi ? b : a);
        else check("R5 R6 R7 R8 R9 R11 dither", c, out_of(c),
                   f_dither(a, b, int'(per_idx[c*3 +: 3]), int'(phase[c*2 +: 2]), n));
        hold_v[c] = out_of(c);
      end
      if (tr == 0) check("R5 low bits ignored", 3, out_of(3), out_of(4));
      pwr_dn[0] = 1'b1;
      tick(1);
      check("R10 power-down", 0, out_of(0), 16'h0000);
      for (int c = 1; c < NCH; c++)
        if (!wave_en[c]) check("R2 no cross effect", c, out_of(c), hold_v[c]);
    end

    if (!wd_hit) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule